// File: doc/BRIEF.md
# Packet UART Transmitter

This block sends packets of bytes on an asynchronous serial line and leaves a programmable idle gap between them. The host writes the payload as 32-bit words into a data queue and then writes one byte count per packet into a command queue. Each packet begins in a fresh word. The block unpacks that word lowest byte first, frames each byte with a start bit, optional parity and a stop bit, and serialises it at a rate set by a phase-accumulator bit clock.

The block also drives the enable of an external half-duplex line driver. The host can hold the enable on, or the block can raise it for the length of each packet and wait a set number of clocks before the first start bit. A mode register holds all settings, and writing it with its top bit set empties both queues and abandons the packet in progress. The host reads the queue levels, a busy flag and a sticky error flag from a status word. Register writes and reads use one simple address-decoded port. Read data is registered and follows the read address one clock later.

Top module: `pkt_uart_tx`

## Requirements
- R1: After reset `txd` is high, `drv_en` is low, and the status word (read address 0), the mode register (read address 2) and the rate register (read address 3) all read 0.
- R2: Each byte goes out as a start bit (low), eight data bits with the least significant bit first, a parity bit when enabled, and one stop bit (high). Each bit lasts one bit time. The line idles high. Every clock the 16-bit rate value (write address 3) is added to a 16-bit accumulator, and each carry out marks one bit boundary, so a rate of 0x4000 gives a bit time of 4 clocks.
- R3: Words written to address 0 are unpacked lowest byte first, bits 7..0 first. Each packet starts with a new word, and the unused upper bytes of a packet's last word are dropped. The bytes of one packet follow each other with no idle time.
- R4: The data queue holds 16 words. A data write while it is full is discarded and sets the error flag (status bit 4). Sixteen words make up one 64-byte packet that is sent intact.
- R5: A write to address 1 queues one packet whose byte count is write bits 9..0. Status bits 20..16 give the number of queued packets not yet begun, and status bit 21 is set while the data queue holds a word.
- R6: Mode bits 15..8 give a gap G. After the stop bit of a packet's last byte, the line stays high for at least G bit times before the next start bit.
- R7: Mode bit 17 enables parity and mode bit 18 selects its sense. With bit 18 at 0 the data bits plus the parity bit hold an even number of ones; with bit 18 at 1 they hold an odd number.
- R8: With mode bit 5 set, `drv_en` is high from the start of a packet until the end of its last stop bit and low otherwise, and mode bit 6 has no effect. With mode bit 5 clear, `drv_en` equals mode bit 6.
- R9: With mode bit 5 set, the first start bit of a packet comes at least (mode bits 3..0) + 1 clocks after `drv_en` rises.
- R10: Status bit 7 (busy) is set from the moment a packet is taken from the command queue until its gap has elapsed, and it is always set while the line is low.
- R11: A write to address 2 with bit 31 set empties both queues, abandons any packet, returns the line high and clears the error flag. Bits 30..0 of that write are stored as the new mode, and bit 31 always reads back 0.
- R12: A count write while the data queue is empty, or while the 16-entry command queue is full, sets the error flag. The flag stays set until a clearing mode write.
- R13: A count of 0 causes no line activity and consumes no data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 count, 2 mode, 3 rate |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 2 mode, 3 rate |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| txd | output | 1 | Serial line output, idles high |
| drv_en | output | 1 | External line driver enable |

## Verification
Properties checked on every cycle: in automatic mode the driver enable covers every low bit on the line; the line is never low unless busy is set; a driver enable edge never coincides with a start bit; the error flag holds until cleared; a clearing write leaves the transmitter idle; and the data queue never exceeds its depth. The actual bytes, the word packing and discarded upper bytes, the parity sense, the length of the inter-packet gap and the lead time, the queue levels in the status word, and the handling of a zero count can only be shown by the bench scenarios. The bench decodes the line and compares it against a cycle-by-cycle model.

// File: rtl/pkt_uart_tx_pkg.sv
package pkt_uart_tx_pkg;
  localparam int CNT_W = 10;
  localparam int WORD_W = 32;

  localparam int M_CLEAR = 31;
  localparam int M_ODD = 18;
  localparam int M_PAR = 17;
  localparam int M_GAP_LO = 8;
  localparam int M_FORCE = 6;
  localparam int M_AUTO = 5;

  localparam int S_HASDATA = 21;
  localparam int S_PKTS_LO = 16;
  localparam int S_BUSY = 7;
  localparam int S_ERR = 4;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_RATE = 2'd3;

  typedef enum logic [2:0] {
    T_IDLE, T_FETCH, T_LEAD, T_START, T_SEND, T_GAP
  } tx_state_t;
endpackage

// File: rtl/ptx_fifo.sv
module ptx_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [AW:0]  count,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty = (count == '0);
  assign full = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
    if (do_pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/ptx_rate.sv
module ptx_rate #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      tick <= 1'b0;
    end else begin
      acc <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/ptx_serial.sv
module ptx_serial
  import pkt_uart_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             tick_i,
  input  logic             cmd_empty_i,
  input  logic [CNT_W-1:0] cmd_val_i,
  input  logic [31:0]      word_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic [7:0]       gap_i,
  input  logic [3:0]       lead_i,
  output logic             cmd_pop_o,
  output logic             data_pop_o,
  output logic             txd_o,
  output logic             act_o,
  output logic             busy_o
);
  tx_state_t st;
  logic [CNT_W-1:0] left;
  logic [1:0] idx;
  logic [3:0] lead_c, nb;
  logic [9:0] sh;
  logic [7:0] gap_c, cur_byte;
  logic par_bit, load;

  assign cur_byte = word_i[{idx, 3'b000} +: 8];
  assign par_bit = (^cur_byte) ^ par_odd_i;
  assign load = tick_i && ((st == T_START) || (st == T_SEND && nb == 4'd0 && left != '0));
  assign cmd_pop_o = !flush_i && st == T_IDLE && !cmd_empty_i;
  assign data_pop_o = !flush_i && ((st == T_FETCH && cmd_val_i != '0) ||
                                   (load && idx == 2'd3 && left > CNT_W'(1)));
  assign busy_o = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      st <= T_IDLE;
      txd_o <= 1'b1;
      act_o <= 1'b0;
      left <= '0;
      idx <= '0;
      lead_c <= '0;
      nb <= '0;
      sh <= '1;
      gap_c <= '0;
    end else begin
      case (st)
        T_IDLE: if (!cmd_empty_i) st <= T_FETCH;
        T_FETCH: begin
          if (cmd_val_i == '0) st <= T_IDLE;
          else begin
            left <= cmd_val_i;
            idx <= 2'd0;
            lead_c <= lead_i;
            act_o <= 1'b1;
            st <= T_LEAD;
          end
        end
        T_LEAD: begin
          if (lead_c != 4'd0) lead_c <= lead_c - 4'd1;
          else st <= T_START;
        end
        T_SEND: begin
          if (tick_i && nb != 4'd0) begin
            txd_o <= sh[0];
            sh <= {1'b1, sh[9:1]};
            nb <= nb - 4'd1;
          end else if (tick_i && left == '0) begin
            act_o <= 1'b0;
            if (gap_i == 8'd0) st <= T_IDLE;
            else begin
              gap_c <= gap_i;
              st <= T_GAP;
            end
          end
        end
        T_GAP: begin
          if (tick_i) begin
            if (gap_c == 8'd1) st <= T_IDLE;
            else gap_c <= gap_c - 8'd1;
          end
        end
        default: ;
      endcase
      if (load) begin
        txd_o <= 1'b0;
        sh <= par_en_i ? {1'b1, par_bit, cur_byte} : {2'b11, cur_byte};
        nb <= par_en_i ? 4'd10 : 4'd9;
        left <= left - CNT_W'(1);
        idx <= idx + 2'd1;
        st <= T_SEND;
      end
    end
  end
endmodule

// File: rtl/pkt_uart_tx.sv
module pkt_uart_tx
  import pkt_uart_tx_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH = 16,
  parameter int RATE_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        txd,
  output logic        drv_en
);
  localparam int DCW = $clog2(DATA_DEPTH) + 1;
  localparam int CCW = $clog2(CMD_DEPTH) + 1;

  logic [30:0] mode_q;
  logic [RATE_W-1:0] rate_q;
  logic err_q, flush, tick, tx_busy, tx_act;
  logic wr_data_q, wr_cmd_q;
  logic d_pop, d_empty, d_full, c_pop, c_empty, c_full;
  logic [31:0] d_out, status;
  logic [CNT_W-1:0] c_out;
  logic [DCW-1:0] data_count;
  logic [CCW-1:0] cmd_count;

  assign flush = wr_en && wr_addr == A_MODE && wr_data[M_CLEAR];
  assign wr_data_q = wr_en && wr_addr == A_DATA;
  assign wr_cmd_q = wr_en && wr_addr == A_CMD;

  ptx_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk(clk), .rst(rst), .flush(flush), .push(wr_data_q), .din(wr_data),
    .pop(d_pop), .dout(d_out), .count(data_count), .empty(d_empty), .full(d_full));

  ptx_fifo #(.W(CNT_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .flush(flush), .push(wr_cmd_q), .din(wr_data[CNT_W-1:0]),
    .pop(c_pop), .dout(c_out), .count(cmd_count), .empty(c_empty), .full(c_full));

  ptx_rate #(.ACC_W(RATE_W)) u_rate (.clk(clk), .rst(rst), .step(rate_q), .tick(tick));

  ptx_serial u_ser (
    .clk(clk), .rst(rst), .flush_i(flush), .tick_i(tick),
    .cmd_empty_i(c_empty), .cmd_val_i(c_out), .word_i(d_out),
    .par_en_i(mode_q[M_PAR]), .par_odd_i(mode_q[M_ODD]),
    .gap_i(mode_q[M_GAP_LO +: 8]), .lead_i(mode_q[3:0]),
    .cmd_pop_o(c_pop), .data_pop_o(d_pop), .txd_o(txd), .act_o(tx_act), .busy_o(tx_busy));

  assign drv_en = mode_q[M_AUTO] ? tx_act : mode_q[M_FORCE];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rate_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[30:0];
      if (wr_en && wr_addr == A_RATE) rate_q <= wr_data[RATE_W-1:0];
      if (flush) err_q <= 1'b0;
      else if ((wr_data_q && d_full) || (wr_cmd_q && (c_full || d_empty))) err_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[S_HASDATA] = !d_empty;
    status[S_PKTS_LO +: 5] = 5'(cmd_count);
    status[S_BUSY] = tx_busy;
    status[S_ERR] = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        2'd0: rd_data <= status;
        2'd2: rd_data <= {1'b0, mode_q};
        2'd3: rd_data <= 32'(rate_q);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pkt_uart_tx_chk.sv
module pkt_uart_tx_chk #(
  parameter int DATA_DEPTH = 16,
  parameter int DCW = 5
) (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic drv_en,
  input logic auto_en,
  input logic busy,
  input logic err,
  input logic flush,
  input logic [DCW-1:0] dcount
);
  a_r8_drive_covers_line: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !txd) |-> drv_en);

  a_r10_busy_while_low: assert property (@(posedge clk) disable iff (rst)
    !txd |-> busy);

  a_r9_no_start_on_rise: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $rose(drv_en)) |-> txd);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !flush) |=> err);

  a_r11_flush_idles: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!busy && txd && !err));

  a_r4_no_overfill: assert property (@(posedge clk) disable iff (rst)
    dcount <= DCW'(DATA_DEPTH));
endmodule

bind pkt_uart_tx pkt_uart_tx_chk #(.DATA_DEPTH(DATA_DEPTH), .DCW(DCW)) u_chk (
  .clk(clk), .rst(rst), .txd(txd), .drv_en(drv_en), .auto_en(mode_q[5]),
  .busy(tx_busy), .err(err_q), .flush(flush), .dcount(data_count));

// File: tb/pkt_uart_tx_bench.sv
`timescale 1ns/1ps
module pkt_uart_tx_bench;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic txd, drv_en;

  always #2 clk = ~clk;

  pkt_uart_tx u_pkt_uart_tx (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd), .drv_en(drv_en));

  int errors = 0, checks = 0, cyc = 0, shown = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] dq[$];
  int cq[$];
  int ms = 0, cur_cnt = 0, left = 0, idx = 0, lead = 0, pos = 0, gapc = 0, acc = 0;
  logic [31:0] cur_word = 0, mmode = 0;
  int mrate = 0;
  logic [7:0] mbyte = 0;
  logic mpe = 0, mpo = 0, mtick = 0, mtx = 1, mact = 0, merr = 0;
  int pdq, pcq, sum, clen;
  logic ld, fl;

  function automatic logic bit_at(int p, logic [7:0] b, logic pe, logic po);
    if (p == 0) return 1'b0;
    if (p <= 8) return b[p-1];
    if (p == 9 && pe) return (($countones(b) % 2) == 1) ^ po;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      dq.delete(); cq.delete();
      ms = 0; acc = 0; mtick = 0; mtx = 1; mact = 0; merr = 0; mmode = 0; mrate = 0; cur_word = 0;
    end else begin
      pdq = dq.size(); pcq = cq.size();
      fl = wr_en && wr_addr == 2 && wr_data[31];
      if (fl) begin
        dq.delete(); cq.delete(); ms = 0; mtx = 1; mact = 0; merr = 0;
      end else begin
        ld = 0;
        case (ms)
          0: if (cq.size() > 0) begin cur_cnt = cq.pop_front(); ms = 1; end
          1: if (cur_cnt == 0) ms = 0;
             else begin
               if (dq.size() > 0) cur_word = dq.pop_front();
               left = cur_cnt; idx = 0; lead = mmode[3:0]; mact = 1; ms = 2;
             end
          2: if (lead != 0) lead--; else ms = 3;
          3: if (mtick) ld = 1;
          4: if (mtick) begin
               clen = mpe ? 11 : 10;
               if (pos < clen - 1) begin pos++; mtx = bit_at(pos, mbyte, mpe, mpo); end
               else if (left > 0) ld = 1;
               else begin
                 mact = 0;
                 if (mmode[15:8] == 0) ms = 0; else begin gapc = mmode[15:8]; ms = 5; end
               end
             end
          5: if (mtick) begin if (gapc == 1) ms = 0; else gapc--; end
          default: ;
        endcase
        if (ld) begin
          mbyte = cur_word[8*idx +: 8];
          mpe = mmode[17]; mpo = mmode[18];
          if (idx == 3 && left > 1 && dq.size() > 0) cur_word = dq.pop_front();
          idx = (idx + 1) % 4; left--; pos = 0; mtx = 0; ms = 4;
        end
      end
      sum = acc + mrate;
      mtick = (sum >= 65536);
      acc = sum % 65536;
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (pdq < 16) dq.push_back(wr_data); else merr = 1;
          2'd1: begin
            if (pcq < 16) cq.push_back(wr_data[9:0]);
            if (pcq >= 16 || pdq == 0) merr = 1;
          end
          2'd2: mmode = {1'b0, wr_data[30:0]};
          default: mrate = wr_data[15:0];
        endcase
      end
    end
  end

  // per-cycle comparison of line and driver enable
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      checks++;
      if (txd !== mtx || drv_en !== (mmode[5] ? mact : mmode[6])) begin
        errors++;
        if (shown < 20) begin
          shown++;
          $display("FAIL R2/R8 cycle %0d got txd=%b drv=%b expected txd=%b drv=%b",
                   cyc, txd, drv_en, mtx, mmode[5] ? mact : mmode[6]);
        end
      end
    end
  end

  // ---------------- line decoder (bit time 4 clocks) ----------------
  logic [7:0] rxq[$], expq[$];
  logic parq[$];
  int runs[$];
  logic dec_on = 0, dec_par = 0, started = 0, low_seen = 0, prev_drv = 0;
  int ph = 0, hi_run = 0, b = 0, t_rise = -1, lead_meas = -1;
  logic [7:0] dbyte = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!txd) low_seen = 1;
      if (drv_en && !prev_drv) t_rise = cyc;
      prev_drv = drv_en;
      if (!dec_on) begin
        if (!txd) begin
          dec_on = 1; ph = 0; dbyte = 0;
          if (started) runs.push_back(hi_run);
          started = 1;
          if (lead_meas < 0 && t_rise >= 0) lead_meas = cyc - t_rise;
        end else hi_run++;
      end else begin
        ph++;
        if (ph >= 6 && ((ph - 2) % 4) == 0) begin
          b = (ph - 6) / 4;
          if (b < 8) dbyte[b] = txd;
          else if (b == 8 && dec_par) parq.push_back(txd);
          else begin
            if (!txd) begin errors++; $display("FAIL R2 stop bit got=0 expected=1"); end
            rxq.push_back(dbyte); dec_on = 0; hi_run = 0;
          end
        end
      end
    end
  end

  // watchdog
  always @(negedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); @(negedge clk); v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!(ms == 0 && cq.size() == 0 && !dec_on)) @(negedge clk);
    idle(20);
  endtask

  task automatic expect_bytes(string req);
    chk({req, " byte count"}, rxq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      chk({req, " byte"}, rxq[i], expq[i]);
    rxq.delete(); expq.delete();
  endtask

  logic [31:0] v;
  int mx;

  initial begin
    idle(4); rst = 0; idle(2);
    // R1: reset state
    chk("R1 txd", txd, 1); chk("R1 drv_en", drv_en, 0);
    rd(0, v); chk("R1 status", v, 0);
    rd(2, v); chk("R1 mode", v, 0);
    rd(3, v); chk("R1 rate", v, 0);

    // R2 R3 R6 R9 R10: two packets of 6 and 7 bytes, gap 2, auto drive, lead 3
    wr(3, 32'h4000);
    wr(2, 32'h0223);
    runs.delete(); started = 0; t_rise = -1; lead_meas = -1;
    wr(0, 32'h04030201); wr(0, 32'hAAAA0605); wr(0, 32'hF4F3F2F1); wr(0, 32'hBBF7F6F5);
    foreach (expq[i]) ;
    expq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
             8'hF1, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hF7};
    wr(1, 6); wr(1, 7);
    idle(20);
    rd(0, v); chk("R10 busy while sending", v[7], 1);
    wait_done();
    expect_bytes("R3");
    mx = 0; foreach (runs[i]) if (runs[i] > mx) mx = runs[i];
    chk("R6 gap at least 2 bit times", (mx >= 9), 1);
    chk("R9 lead at least 4 clocks", (lead_meas >= 4), 1);
    chk("R8 auto drive off after packet", drv_en, 0);
    rd(0, v); chk("R10 idle status", v, 0);

    // R7: even then odd parity on byte 0x07
    dec_par = 1;
    wr(2, 32'h20020); wr(0, 32'h07); wr(1, 1); wait_done();
    wr(2, 32'h60020); wr(0, 32'h07); wr(1, 1); wait_done();
    dec_par = 0;
    chk("R7 parity entries", parq.size(), 2);
    if (parq.size() == 2) begin
      chk("R7 even parity bit", parq[0], 1);
      chk("R7 odd parity bit", parq[1], 0);
    end
    expq = '{8'h07, 8'h07}; expect_bytes("R2");

    // R8: manual drive and auto priority
    wr(2, 32'h40); idle(3); chk("R8 forced on", drv_en, 1);
    wr(2, 32'h60); idle(3); chk("R8 auto overrides force", drv_en, 0);

    // R4: 16 words as one 64-byte packet
    wr(2, 32'h20);
    for (int w = 0; w < 16; w++) begin
      wr(0, {8'(w*4+3+16), 8'(w*4+2+16), 8'(w*4+1+16), 8'(w*4+16)});
      for (int k = 0; k < 4; k++) expq.push_back(8'(w*4+k+16));
    end
    rd(0, v); chk("R5 data present", v[21], 1);
    wr(1, 64); wait_done();
    expect_bytes("R4");
    rd(0, v); chk("R4 no error on full use", v[4], 0);

    // R5 R11: stall the bit clock, queue three packets
    wr(3, 0); idle(4);
    wr(2, 32'h8000_0223);
    wr(0, 32'h11111111); wr(0, 32'h22222222); wr(0, 32'h33333333);
    wr(1, 4); wr(1, 4); wr(1, 4);
    idle(10);
    rd(0, v); chk("R5 status with two waiting", v, 32'h0022_0080);
    chk("R8 auto drive during lead", drv_en, 1);
    wr(2, 32'h8000_0223); idle(2);
    rd(0, v); chk("R11 status cleared", v, 0);
    rd(2, v); chk("R11 mode stored without bit 31", v, 32'h0223);
    chk("R11 line high", txd, 1);

    // R4: overflow of data queue
    for (int w = 0; w < 17; w++) wr(0, w);
    rd(0, v); chk("R4 overflow error", v, 32'h0020_0010);
    wr(2, 32'h8000_0000);
    rd(0, v); chk("R11 error cleared", v, 0);

    // R12: count with empty data queue
    wr(1, 1); idle(6);
    rd(0, v); chk("R12 error on empty data", v[4], 1);
    idle(10);
    rd(0, v); chk("R12 error held", v[4], 1);
    wr(2, 32'h8000_0000);

    // R13: zero count
    wr(3, 32'h4000);
    wr(0, 32'hDEADBEEF);
    low_seen = 0;
    wr(1, 0); idle(60);
    chk("R13 no line activity", low_seen, 0);
    rd(0, v); chk("R13 word kept, idle, no error", v, 32'h0020_0000);
    wr(2, 32'h8000_0000); idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule